// File: doc/BRIEF.md
# Write-Completion Status Read Responder

This block sits on the read path of a byte-wide nonvolatile memory. While the array is running an internal programming cycle it replaces the data returned to the host with a status pattern: the top data bit carries the complement of the top bit of the byte most recently written, and the bit below it alternates from one read access to the next. Host software can therefore tell that programming is still in progress. It polls either for the top bit to match the data it wrote, or for the alternating bit to stop changing. When the busy flag drops, reads return the array contents unchanged.

Bus control is active low. A read access exists only while both the chip-select and the output-enable strobes are low, and the output-enable of the tristate driver follows that condition. A small state machine tracks the programming cycle and read accesses:

- ST_IDLE: no programming in progress.
- ST_PROG_WAIT: busy, with no read open.
- ST_PROG_READ: busy, with a read open.

Its transitions are:

- ENTER_PROG: ST_IDLE to ST_PROG_WAIT when busy rises. This also reloads the alternating bit.
- OPEN_READ: ST_PROG_WAIT to ST_PROG_READ when a read begins.
- CLOSE_READ: ST_PROG_READ to ST_PROG_WAIT when the read ends. This flips the alternating bit.
- LEAVE_PROG: any busy state to ST_IDLE when busy falls.

All inputs are taken to be synchronous to `clk`.

Top module: `poll_status_responder`

## Requirements
- R1: `bus_oe` is 1 exactly while `ce_n` and `oe_n` are both 0. Whenever `bus_oe` is 0, `bus_out` is all zeros.
- R2: While `busy` is 0, a read returns `array_rd_data` unchanged.
- R3: While `busy` is 1, a read returns bit 7 of `bus_out` as the inverse of bit 7 of `last_wr_byte`.
- R4: While `busy` is 1, bit 6 of `bus_out` flips once for each completed read access, on the clock edge after the access closes. It does not change per clock cycle within an access.
- R5: An access with only one of `ce_n` and `oe_n` low is not a read. It leaves `bus_oe` at 0 and does not advance bit 6.
- R6: Bit 6 returns 0 on the first read of every new busy period, whatever value it held in the previous one.
- R7: While `busy` is 1, bits 5 to 0 of a read are driven as 0.
- R8: When `busy` falls during an open read, the read data switches to `array_rd_data` in the same cycle, and that access does not flip bit 6.
- R9: After reset, with no read, `bus_oe` is 0 and `bus_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Internal programming cycle in progress |
| last_wr_byte | input | 8 | Copy of the byte most recently written |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| array_rd_data | input | 8 | Data read from the array |
| bus_out | output | 8 | Value driven onto the data bus |
| bus_oe | output | 1 | Tristate driver enable |

## Verification
The idle path is swept over all 256 array values, which separates true pass-through from any masking of bits. For each of the 256 possible last-written bytes, a busy period is opened and read three times, with array data that differs from the expected status. This separates the inverted poll bit from the raw bit, confirms the reserved bits are zeroed, and shows the 0-1-0 toggle sequence restarting in each period. Partial-select pulses and long reads spanning several clocks show that only whole accesses advance the toggle. A busy flag dropped in the middle of a read shows the immediate hand-back to array data.

// File: rtl/psr_pkg.sv
package psr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_PROG_WAIT = 2'd1,
        ST_PROG_READ = 2'd2
    } psr_state_e;

endpackage

// File: rtl/psr_access_decode.sv
module psr_access_decode (
    input  logic ce_n,
    input  logic oe_n,
    output logic read_en
);

    // a read needs both active-low strobes asserted together
    always_comb begin
        read_en = ~ce_n & ~oe_n;
    end

endmodule

// File: rtl/psr_status_fsm.sv
module psr_status_fsm #(
    parameter logic TOG_INIT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 busy,
    input  logic                 read_en,
    output psr_pkg::psr_state_e  state_q,
    output logic                 tog_q
);

    import psr_pkg::*;

    psr_state_e state_d;
    logic       enter_prog;
    logic       close_read;

    // next-state decode
    always_comb begin
        state_d    = state_q;
        enter_prog = 1'b0;
        close_read = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (busy) begin
                    state_d    = ST_PROG_WAIT;
                    enter_prog = 1'b1;
                end
            end
            ST_PROG_WAIT: begin
                if (!busy) begin
                    state_d = ST_IDLE;
                end else if (read_en) begin
                    state_d = ST_PROG_READ;
                end
            end
            ST_PROG_READ: begin
                if (!busy) begin
                    state_d = ST_IDLE;
                end else if (!read_en) begin
                    state_d    = ST_PROG_WAIT;
                    close_read = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // toggle output register: reload on entry, flip per closed read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q <= TOG_INIT;
        end else if (enter_prog) begin
            tog_q <= TOG_INIT;
        end else if (close_read) begin
            tog_q <= ~tog_q;
        end
    end

endmodule

// File: rtl/psr_data_mux.sv
module psr_data_mux #(
    parameter int   DATA_W   = 8,
    parameter logic TOG_INIT = 1'b0
) (
    input  logic                 busy,
    input  logic                 read_en,
    input  psr_pkg::psr_state_e  state_q,
    input  logic                 tog_q,
    input  logic [DATA_W-1:0]    last_wr_byte,
    input  logic [DATA_W-1:0]    array_rd_data,
    output logic [DATA_W-1:0]    bus_out
);

    import psr_pkg::*;

    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    logic              tog_view;
    logic [DATA_W-1:0] status_word;

    // in the first busy cycle the register has not reloaded yet
    always_comb begin
        tog_view = (state_q == ST_IDLE) ? TOG_INIT : tog_q;
    end

    always_comb begin
        status_word           = '0;
        status_word[POLL_BIT] = ~last_wr_byte[POLL_BIT];
        status_word[TOG_BIT]  = tog_view;
    end

    always_comb begin
        if (!read_en) begin
            bus_out = '0;
        end else if (busy) begin
            bus_out = status_word;
        end else begin
            bus_out = array_rd_data;
        end
    end

endmodule

// File: rtl/poll_status_responder.sv
module poll_status_responder #(
    parameter int   DATA_W   = 8,
    parameter logic TOG_INIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [DATA_W-1:0] last_wr_byte,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] array_rd_data,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);

    import psr_pkg::*;

    logic       read_en;
    psr_state_e state_q;
    logic       tog_q;

    psr_access_decode u_decode (
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .read_en (read_en)
    );

    psr_status_fsm #(
        .TOG_INIT (TOG_INIT)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .read_en (read_en),
        .state_q (state_q),
        .tog_q   (tog_q)
    );

    psr_data_mux #(
        .DATA_W   (DATA_W),
        .TOG_INIT (TOG_INIT)
    ) u_mux (
        .busy          (busy),
        .read_en       (read_en),
        .state_q       (state_q),
        .tog_q         (tog_q),
        .last_wr_byte  (last_wr_byte),
        .array_rd_data (array_rd_data),
        .bus_out       (bus_out)
    );

    assign bus_oe = read_en;

endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
    parameter int DATA_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic [DATA_W-1:0]    last_wr_byte,
    input logic                 ce_n,
    input logic                 oe_n,
    input logic [DATA_W-1:0]    array_rd_data,
    input logic [DATA_W-1:0]    bus_out,
    input logic                 bus_oe,
    input psr_pkg::psr_state_e  state_q,
    input logic                 tog_q
);

    import psr_pkg::*;

    p_read_drives_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n) |-> bus_oe);

    p_hiz_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (!bus_oe && bus_out == '0));

    p_idle_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_oe) |-> (bus_out == array_rd_data));

    p_poll_inverted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_oe) |-> (bus_out[DATA_W-1] == ~last_wr_byte[DATA_W-1]));

    p_toggle_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG_READ && busy && (ce_n || oe_n)) |=> (tog_q != $past(tog_q)));

    p_toggle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG_READ && busy && !ce_n && !oe_n) |=> $stable(tog_q));

    p_toggle_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && busy) |=> (tog_q == 1'b0));

    p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_oe) |-> (bus_out[DATA_W-3:0] == '0));

endmodule

bind poll_status_responder psr_checker #(.DATA_W(DATA_W)) u_psr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .last_wr_byte  (last_wr_byte),
    .ce_n          (ce_n),
    .oe_n          (oe_n),
    .array_rd_data (array_rd_data),
    .bus_out       (bus_out),
    .bus_oe        (bus_oe),
    .state_q       (state_q),
    .tog_q         (tog_q)
);

// File: tb/test_poll_status_responder.sv
module test_poll_status_responder;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy = 1'b0;
    logic [7:0] last_wr_byte = '0;
    logic       ce_n = 1'b1;
    logic       oe_n = 1'b1;
    logic [7:0] array_rd_data = '0;
    logic [7:0] bus_out;
    logic       bus_oe;

    int  n_tests = 0;
    int  n_fail  = 0;
    logic exp_tog = 1'b0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    poll_status_responder i_poll_status_responder (
        .clk           (clk),
        .rst_n         (rst_n),
        .busy          (busy),
        .last_wr_byte  (last_wr_byte),
        .ce_n          (ce_n),
        .oe_n          (oe_n),
        .array_rd_data (array_rd_data),
        .bus_out       (bus_out),
        .bus_oe        (bus_oe)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] status_of(input logic [7:0] lb, input logic t);
        return {~lb[7], t, 6'b0};
    endfunction

    // read held over hold_clks edges; checks the word at open and before close
    task automatic do_read(input string req, input int hold_clks);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
        #1;
        chk(req, {bus_oe, bus_out}, {1'b1, busy ? status_of(last_wr_byte, exp_tog) : array_rd_data});
        for (int k = 0; k < hold_clks; k++) @(negedge clk);
        #1;
        chk({req, " hold"}, {bus_oe, bus_out},
            {1'b1, busy ? status_of(last_wr_byte, exp_tog) : array_rd_data});
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        #1;
        chk("R1 release", {bus_oe, bus_out}, 9'h000);
        @(negedge clk);
        if (busy) exp_tog = ~exp_tog;
    endtask

    task automatic start_busy(input logic [7:0] lb);
        @(negedge clk);
        last_wr_byte = lb;
        busy = 1'b1;
        exp_tog = 1'b0;
        @(negedge clk);
    endtask

    task automatic end_busy;
        @(negedge clk);
        busy = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R9 reset", {bus_oe, bus_out}, 9'h000);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: idle pass-through over every array value
        for (int v = 0; v < 256; v++) begin
            array_rd_data = v[7:0];
            do_read("R2 idle pass", 0);
        end

        // R3 R4 R6 R7: every last-written byte, three polls each
        for (int lb = 0; lb < 256; lb++) begin
            array_rd_data = lb[7:0] ^ 8'h5A;
            start_busy(lb[7:0]);
            do_read("R6 R3 R7 first poll", 0);
            do_read("R4 second poll", 1);
            do_read("R4 third poll", 2);
            end_busy();
            do_read("R2 after busy", 0);
        end

        // R5: partial selects do not count as reads
        start_busy(8'h3C);
        do_read("R4 poll", 0);
        @(negedge clk); ce_n = 1'b0;
        #1; chk("R5 ce only", {bus_oe, bus_out}, 9'h000);
        @(negedge clk); @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
        #1; chk("R5 oe only", {bus_oe, bus_out}, 9'h000);
        @(negedge clk); @(negedge clk); oe_n = 1'b1;
        do_read("R5 toggle unchanged", 0);

        // R8: busy falls during an open read
        array_rd_data = 8'hC7;
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
        #1; chk("R8 status before drop", {bus_oe, bus_out}, {1'b1, status_of(8'h3C, exp_tog)});
        @(negedge clk); @(negedge clk);
        busy = 1'b0;
        #1; chk("R8 array after drop", {bus_oe, bus_out}, {1'b1, 8'hC7});
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        do_read("R8 idle afterwards", 0);
        start_busy(8'h81);
        do_read("R6 R8 restart at zero", 0);
        end_busy();

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule